// File: doc/BRIEF.md
# Debug Register Access Unit

This unit is the access path to a processor's eight debug register slots. A request names a slot with a 3-bit number and either reads or writes it. Each request also carries the current privilege level, the execution mode (real, protected, virtual-8086 or 64-bit) and the debug-extension enable bit from the control register. Before any data moves, the unit checks the privilege and mode, resolves the two legacy alias slots and applies the general-detect trap. It then replies with read data or with a fault code.

Slots 4 and 5 hold no storage of their own. While the extension bit is clear they stand for slots 6 and 7. While it is set, naming them is an undefined-opcode fault. Bit 13 of slot 7 is the general-detect bit. While it is set, every access that passes the earlier checks is refused with a debug trap, and the unit clears the bit so that the trap handler can reach the registers. Every request gets exactly one response in the following cycle.

Top module: `dbg_reg_unit`

## Requirements
- R1: In 64-bit mode (mode code 3) a write stores all 64 bits of the selected slot, and a later read returns them unchanged.
- R2: Outside 64-bit mode (mode codes 0, 1, 2) a write stores the low 32 bits with the upper 32 bits cleared, and a read returns the low 32 bits with the upper 32 bits zero.
- R3: While the extension bit is 0, slot 4 reads and writes slot 6, and slot 5 reads and writes slot 7.
- R4: While the extension bit is 1, any request naming slot 4 or 5 returns fault code 2 (undefined opcode) and changes no register.
- R5: Any request in virtual-8086 mode (mode code 2) returns fault code 1 (general protection) and changes no register.
- R6: In protected or 64-bit mode a privilege level other than 0 returns fault code 1 and changes no register. In real mode (mode code 0) the privilege level is ignored.
- R7: While bit 13 of slot 7 is 1, a request that passes the R4 to R6 checks returns fault code 3 (debug trap). The requested read or write is not performed, and bit 13 of slot 7 is cleared.
- R8: The faults are ranked general protection, then undefined opcode, then debug trap. Only the highest-ranked applicable fault is reported, and a lower-ranked fault has no side effect.
- R9: After reset all slots read as zero and no response is signalled.
- R10: Each request produces a one-cycle `rspValid` pulse on the following clock edge. `rspFault` is 0 on success. `rspData` is zero for writes and for faulted requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSel | input | 3 | Debug slot number 0 to 7 |
| reqData | input | 64 | Write data |
| privLevel | input | 2 | Current privilege level |
| cpuMode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 64-bit |
| extEnable | input | 1 | Debug-extension enable bit |
| rspValid | output | 1 | Response pulse, one cycle after the request |
| rspFault | output | 2 | 0 none, 1 general protection, 2 undefined opcode, 3 debug trap |
| rspData | output | 64 | Read data |

## Verification
A table of requests is replayed in a fixed order, so that each result depends on the register state left by the requests before it. 64-bit and narrow accesses tell the full-width path apart from the truncating one. Reads and writes through slots 4 and 5, with the extension bit clear and then set, separate aliasing from trapping. Requests that meet two fault conditions at once (privilege with alias, alias with general detect, privilege with general detect) pin down the ranking, and a read-back after each such request shows that a lower-ranked fault left no side effect, in particular that the general-detect bit survives a protection fault.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int DATA_W   = 64;
  localparam int NARROW_W = 32;
  localparam int SEL_W    = 3;
  localparam int NUM_SLOT = 1 << SEL_W;
  localparam int GD_BIT   = 13;
  localparam int ALIAS_LO = 4;
  localparam int ALIAS_HI = 5;
  localparam int STAT_IDX = 6;
  localparam int CTRL_IDX = 7;
  localparam int ALIAS_OFS = STAT_IDX - ALIAS_LO;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2,
    FLT_DB   = 2'd3
  } fault_e;

  typedef struct packed {
    logic             respond;
    logic             wrEn;
    logic             rdEn;
    logic             narrow;
    logic             clrGd;
    logic [SEL_W-1:0] idx;
    fault_e           fault;
  } strobe_t;
endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [SEL_W-1:0] reqSel,
  input  logic [1:0]       privLevel,
  input  logic [1:0]       cpuMode,
  input  logic             extEnable,
  input  logic             gdBit,
  output strobe_t          strb
);
  logic aliasHit, gpHit, udHit;
  fault_e fault;

  always_comb begin
    aliasHit = (reqSel == SEL_W'(ALIAS_LO)) || (reqSel == SEL_W'(ALIAS_HI));
    gpHit    = (cpuMode == MODE_V86) || ((cpuMode != MODE_REAL) && (privLevel != 2'd0));
    udHit    = extEnable && aliasHit;
    if (gpHit)      fault = FLT_GP;
    else if (udHit) fault = FLT_UD;
    else if (gdBit) fault = FLT_DB;
    else            fault = FLT_NONE;

    strb.respond = reqValid;
    strb.fault   = reqValid ? fault : FLT_NONE;
    strb.wrEn    = reqValid && reqWrite && (fault == FLT_NONE);
    strb.rdEn    = reqValid && !reqWrite && (fault == FLT_NONE);
    strb.clrGd   = reqValid && (fault == FLT_DB);
    strb.narrow  = (cpuMode != MODE_LONG);
    strb.idx     = (aliasHit && !extEnable) ? reqSel + SEL_W'(ALIAS_OFS) : reqSel;
  end

  // R5
  v86_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cpuMode == MODE_V86) |-> (!strb.wrEn && !strb.rdEn));

  // R4
  alias_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && extEnable && (reqSel == 3'd4 || reqSel == 3'd5)) |-> (!strb.wrEn && !strb.rdEn));
endmodule

// File: rtl/dbg_dpath.sv
module dbg_dpath
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              gdBit,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] slots [NUM_SLOT];
  logic [DATA_W-1:0] wrVal;
  logic [DATA_W-1:0] rdVal;

  always_comb begin
    wrVal = strb.narrow ? {{(DATA_W-NARROW_W){1'b0}}, wrData[NARROW_W-1:0]} : wrData;
    rdVal = strb.narrow ? {{(DATA_W-NARROW_W){1'b0}}, slots[strb.idx][NARROW_W-1:0]}
                        : slots[strb.idx];
  end

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    if (i == ALIAS_LO || i == ALIAS_HI) begin : g_none
      always_ff @(posedge clk) slots[i] <= '0;
    end else if (i == CTRL_IDX) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rstN)                                        slots[i] <= '0;
        else if (strb.wrEn && strb.idx == SEL_W'(i))      slots[i] <= wrVal;
        else if (strb.clrGd)                              slots[i][GD_BIT] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)                                        slots[i] <= '0;
        else if (strb.wrEn && strb.idx == SEL_W'(i))      slots[i] <= wrVal;
      end
    end
  end

  assign gdBit = slots[CTRL_IDX][GD_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= FLT_NONE;
      rspData  <= '0;
    end else begin
      rspValid <= strb.respond;
      rspFault <= strb.fault;
      rspData  <= strb.rdEn ? rdVal : '0;
    end
  end

  // R7
  gd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrGd |=> !gdBit);

  // R10
  fault_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspData == '0));

  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.narrow) |=> (rspData[DATA_W-1:NARROW_W] == '0));

  // R3
  alias_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn) |-> (strb.idx != SEL_W'(ALIAS_LO) && strb.idx != SEL_W'(ALIAS_HI)));
endmodule

// File: rtl/dbg_reg_unit.sv
module dbg_reg_unit
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [2:0]        reqSel,
  input  logic [63:0]       reqData,
  input  logic [1:0]        privLevel,
  input  logic [1:0]        cpuMode,
  input  logic              extEnable,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [63:0]       rspData
);
  strobe_t strb;
  logic    gdBit;

  dbg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .privLevel(privLevel), .cpuMode(cpuMode),
    .extEnable(extEnable), .gdBit(gdBit), .strb(strb)
  );

  dbg_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(reqData), .gdBit(gdBit),
    .rspValid(rspValid), .rspFault(rspFault), .rspData(rspData)
  );

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(reqValid)) |-> 1'b0);
endmodule

// File: tb/dbg_reg_unit_bench.sv
module dbg_reg_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [63:0] data;
    logic [1:0]  cpl;
    logic [1:0]  mode;
    logic        de;
    logic [1:0]  expFault;
    logic [63:0] expData;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 27;
  // mode: 0 real 1 prot 2 v86 3 long; fault: 0 none 1 GP 2 UD 3 DB
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd0, 64'h1111_2222_3333_4444, 2'd0, 2'd3, 1'b0, 2'd0, 64'h0, 4'd1},                  // R1
    '{1'b0, 3'd0, 64'h0, 2'd0, 2'd3, 1'b0, 2'd0, 64'h1111_2222_3333_4444, 4'd1},                  // R1
    '{1'b0, 3'd0, 64'h0, 2'd0, 2'd1, 1'b0, 2'd0, 64'h0000_0000_3333_4444, 4'd2},                  // R2
    '{1'b1, 3'd6, 64'hAAAA_BBBB_CCCC_DDDD, 2'd0, 2'd1, 1'b0, 2'd0, 64'h0, 4'd2},                  // R2
    '{1'b0, 3'd4, 64'h0, 2'd0, 2'd3, 1'b0, 2'd0, 64'h0000_0000_CCCC_DDDD, 4'd3},                  // R3
    '{1'b1, 3'd5, 64'h55, 2'd0, 2'd3, 1'b0, 2'd0, 64'h0, 4'd3},                                   // R3
    '{1'b0, 3'd7, 64'h0, 2'd0, 2'd3, 1'b0, 2'd0, 64'h55, 4'd3},                                   // R3
    '{1'b0, 3'd4, 64'h0, 2'd0, 2'd3, 1'b1, 2'd2, 64'h0, 4'd4},                                    // R4
    '{1'b1, 3'd5, 64'h77, 2'd0, 2'd3, 1'b1, 2'd2, 64'h0, 4'd4},                                   // R4
    '{1'b0, 3'd7, 64'h0, 2'd0, 2'd3, 1'b1, 2'd0, 64'h55, 4'd4},                                   // R4
    '{1'b0, 3'd1, 64'h0, 2'd3, 2'd1, 1'b0, 2'd1, 64'h0, 4'd6},                                    // R6
    '{1'b1, 3'd1, 64'hFF, 2'd3, 2'd1, 1'b0, 2'd1, 64'h0, 4'd6},                                   // R6
    '{1'b0, 3'd1, 64'h0, 2'd0, 2'd1, 1'b0, 2'd0, 64'h0, 4'd6},                                    // R6
    '{1'b1, 3'd2, 64'h99, 2'd0, 2'd2, 1'b0, 2'd1, 64'h0, 4'd5},                                   // R5
    '{1'b0, 3'd2, 64'h0, 2'd0, 2'd3, 1'b0, 2'd0, 64'h0, 4'd5},                                    // R5
    '{1'b1, 3'd3, 64'h0000_1234_5678_9ABC, 2'd3, 2'd0, 1'b0, 2'd0, 64'h0, 4'd6},                  // R6
    '{1'b0, 3'd3, 64'h0, 2'd2, 2'd0, 1'b0, 2'd0, 64'h0000_0000_5678_9ABC, 4'd6},                  // R6
    '{1'b0, 3'd4, 64'h0, 2'd3, 2'd1, 1'b1, 2'd1, 64'h0, 4'd8},                                    // R8
    '{1'b1, 3'd7, 64'h2000, 2'd0, 2'd3, 1'b0, 2'd0, 64'h0, 4'd7},                                 // R7
    '{1'b0, 3'd5, 64'h0, 2'd0, 2'd3, 1'b1, 2'd2, 64'h0, 4'd8},                                    // R8
    '{1'b1, 3'd0, 64'hDEAD, 2'd0, 2'd3, 1'b0, 2'd3, 64'h0, 4'd7},                                 // R7
    '{1'b0, 3'd7, 64'h0, 2'd0, 2'd3, 1'b0, 2'd0, 64'h0, 4'd7},                                    // R7
    '{1'b0, 3'd0, 64'h0, 2'd0, 2'd3, 1'b0, 2'd0, 64'h1111_2222_3333_4444, 4'd7},                  // R7
    '{1'b1, 3'd7, 64'h2055, 2'd0, 2'd3, 1'b0, 2'd0, 64'h0, 4'd8},                                 // R8
    '{1'b0, 3'd0, 64'h0, 2'd1, 2'd1, 1'b0, 2'd1, 64'h0, 4'd8},                                    // R8
    '{1'b0, 3'd7, 64'h0, 2'd0, 2'd3, 1'b0, 2'd3, 64'h0, 4'd8},                                    // R8
    '{1'b0, 3'd7, 64'h0, 2'd0, 2'd3, 1'b0, 2'd0, 64'h55, 4'd8}                                    // R8
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, extEnable = 1'b0;
  logic [2:0] reqSel = '0;
  logic [63:0] reqData = '0;
  logic [1:0] privLevel = '0, cpuMode = '0;
  logic rspValid;
  logic [1:0] rspFault;
  logic [63:0] rspData;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_reg_unit u_dbg_reg_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .reqData(reqData), .privLevel(privLevel), .cpuMode(cpuMode),
    .extEnable(extEnable), .rspValid(rspValid), .rspFault(rspFault), .rspData(rspData)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic wr, input logic [2:0] sel, input logic [63:0] d,
                      input logic [1:0] cpl, input logic [1:0] mode, input logic de,
                      output logic v, output logic [1:0] f, output logic [63:0] q);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSel = sel; reqData = d;
    privLevel = cpl; cpuMode = mode; extEnable = de;
    @(negedge clk);
    reqValid = 1'b0;
    v = rspValid; f = rspFault; q = rspData;
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic v;
    logic [1:0] f;
    logic [63:0] q;
    repeat (3) @(negedge clk);
    check("R9 rspValid in reset", {63'b0, rspValid}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {63'b0, rspValid}, 64'h0);
    for (int s = 0; s < 8; s++) begin
      doOp(1'b0, 3'(s), 64'h0, 2'd0, 2'd3, 1'b0, v, f, q);
      check("R9 slot zero after reset", q, 64'h0);
    end

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      doOp(VECS[i].wr, VECS[i].sel, VECS[i].data, VECS[i].cpl, VECS[i].mode, VECS[i].de, v, f, q);
      tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
      check({tag, " valid"}, {63'b0, v}, 64'h1);
      check({tag, " fault"}, {62'b0, f}, {62'b0, VECS[i].expFault});
      check({tag, " data"}, q, VECS[i].expData);
    end

    // R10 pulse lasts one cycle, write returns zero data
    doOp(1'b1, 3'd1, 64'hFFFF, 2'd0, 2'd3, 1'b0, v, f, q);
    check("R10 write data zero", q, 64'h0);
    @(negedge clk);
    check("R10 pulse one cycle", {63'b0, rspValid}, 64'h0);

    // R1 full width in another slot
    doOp(1'b1, 3'd2, 64'h8000_0000_0000_0001, 2'd0, 2'd3, 1'b0, v, f, q);
    doOp(1'b0, 3'd2, 64'h0, 2'd0, 2'd3, 1'b0, v, f, q);
    check("R1 top bit kept", q, 64'h8000_0000_0000_0001);

    // R9 reset mid-run clears storage
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doOp(1'b0, 3'd0, 64'h0, 2'd0, 2'd3, 1'b0, v, f, q);
    check("R9 slot0 cleared", q, 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule